// File: doc/BRIEF.md
# Serial Segment Data Loader

This block receives segment data for a multiplexed display driver as a serial bit stream with its own data clock. Each frame starts with a short address prefix that is compared with the driver's strapped chip address, so several drivers can share one data and clock pair. When the prefix matches, the following 128 data bits are shifted in. They are then copied into a holding latch, either automatically once the 128th data bit arrives or at the moment a framing enable line drops.

The latched word is handed into a display clock domain that runs with no fixed relation to the data clock. The hand-off updates all 128 bits in the same display cycle, so the waveform logic never sees a mix of two frames. Inside the display domain the word is split into four 32-bit groups, one for each backplane phase, and a phase select picks the group that drives the frontplanes.

Top module: `segLoader`

## Requirements
- R1: `serData` is sampled on the rising edge of `serClk`. A frame is 3 address bits, most significant first, followed by data bits; the first data bit lands in `segWord[127]` and the last in `segWord[0]`.
- R2: When the 3-bit prefix differs from `chipAddr`, the following 128 bits of that frame are ignored: `segWord` keeps its value and `frameUpd` does not pulse.
- R3: With `autoMode` = 1, `frameEn` has no effect; a matched frame is latched on the edge of its 128th data bit, and the next bit is taken as the first address bit of a new frame.
- R4: With `autoMode` = 0, bits are accepted only on edges where `frameEn` = 1, and no transfer happens while `frameEn` stays 1; the transfer happens on the first `serClk` rising edge that samples `frameEn` = 0 after an edge that sampled 1.
- R5: With `autoMode` = 0, any edge that samples `frameEn` = 0 clears the bit count and the address match, so a frame cut short before its 128th data bit is discarded and the next frame starts again with its address.
- R6: With `autoMode` = 0, data bits beyond the 128th keep shifting while `frameEn` = 1, so the transfer holds the last 128 bits received.
- R7: Each transfer updates all of `segWord` in a single `dispClk` cycle, within six `dispClk` cycles after the `serClk` edge that triggers it, and `frameUpd` is high for exactly that one cycle.
- R8: `grpData` shows group `bpPhase`, where group n is `segWord[127-32n : 96-32n]`, so group 0 holds the first 32 data bits of the frame.
- R9: While `rstN` = 0, `segWord` and `frameUpd` are 0 and the bit count and address match are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serClk | input | 1 | Serial data clock; data is sampled on its rising edge |
| dispClk | input | 1 | Display domain clock, asynchronous to serClk |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| serData | input | 1 | Serial address and data stream |
| frameEn | input | 1 | Framing enable; its falling edge triggers the transfer when autoMode is 0 |
| autoMode | input | 1 | Strap: 1 = transfer after 128 data bits, 0 = transfer on frameEn falling |
| chipAddr | input | 3 | Strapped address of this driver |
| bpPhase | input | 2 | Backplane phase selecting the group shown on grpData |
| segWord | output | 128 | Latched segment word in the display domain |
| grpData | output | 32 | Segment group for the selected backplane phase |
| frameUpd | output | 1 | One-cycle pulse in the display domain when segWord takes a new frame |

## Verification
The bound checker watches every cycle for these properties: the bit count stays within one frame and wraps after the 128th data bit in automatic mode; an idle enable clears the count and the match; a transfer happens only for a matched frame and flips the hand-off toggle; the holding latch stays put between transfers; and the display word changes only together with a single-cycle update pulse. What the word actually contains can only be shown by the bench scenarios. These cover bit order and group placement, the full sweep of chip addresses against stream addresses, frames cut short or run long under the enable line, and the enable line having no effect in automatic mode.

// File: rtl/segLoaderPkg.sv
`timescale 1ns/1ps
package segLoaderPkg;

  // Strobes from the serial-domain control to the serial-domain datapath.
  typedef struct packed {
    logic addrShift;  // take serData into the address prefix register
    logic dataShift;  // take serData into the 128-bit shift register
    logic latchNow;   // copy the shifted word into the holding latch
  } loadStrobes_t;

endpackage

// File: rtl/segLoaderCtrl.sv
`timescale 1ns/1ps
module segLoaderCtrl
  import segLoaderPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 128,
  parameter int CNT_W  = $clog2(ADDR_W + WORD_W + 1)
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              autoMode,
  input  logic              frameEn,
  input  logic [ADDR_W-1:0] chipAddr,
  input  logic [ADDR_W-1:0] addrCand,
  output loadStrobes_t      strb,
  output logic [CNT_W-1:0]  cntQ,
  output logic              matchQ
);

  localparam logic [CNT_W-1:0] cAddrLast = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] cAddrEnd  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] cLastBit  = CNT_W'(ADDR_W + WORD_W - 1);
  localparam logic [CNT_W-1:0] cFull     = CNT_W'(ADDR_W + WORD_W);

  logic enPrev;
  logic active;
  logic inAddr;
  logic enFall;

  always_comb begin
    active = autoMode | frameEn;
    inAddr = (cntQ < cAddrEnd);
    enFall = !autoMode && enPrev && !frameEn;

    strb.addrShift = active && inAddr;
    strb.dataShift = active && !inAddr && matchQ;
    strb.latchNow  = (autoMode && strb.dataShift && (cntQ == cLastBit)) ||
                     (enFall && matchQ && (cntQ == cFull));
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      matchQ <= 1'b0;
      enPrev <= 1'b0;
    end else begin
      enPrev <= frameEn;
      if (!active) begin
        cntQ   <= '0;
        matchQ <= 1'b0;
      end else if (inAddr) begin
        cntQ <= cntQ + 1'b1;
        if (cntQ == cAddrLast) begin
          matchQ <= (addrCand == chipAddr);
        end
      end else if (autoMode && (cntQ == cLastBit)) begin
        cntQ   <= '0;
        matchQ <= 1'b0;
      end else if (cntQ != cFull) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

endmodule

// File: rtl/segLoaderData.sv
`timescale 1ns/1ps
module segLoaderData
  import segLoaderPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 128
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              serData,
  input  loadStrobes_t      strb,
  output logic [ADDR_W-1:0] addrCand,
  output logic [WORD_W-1:0] holdWord,
  output logic              reqTgl
);

  logic [ADDR_W-2:0] addrSh;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextShift;

  always_comb begin
    addrCand  = {addrSh, serData};
    nextShift = {shiftReg[WORD_W-2:0], serData};
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      addrSh   <= '0;
      shiftReg <= '0;
      holdWord <= '0;
      reqTgl   <= 1'b0;
    end else begin
      if (strb.addrShift) begin
        addrSh <= addrCand[ADDR_W-2:0];
      end
      if (strb.dataShift) begin
        shiftReg <= nextShift;
      end
      if (strb.latchNow) begin
        holdWord <= strb.dataShift ? nextShift : shiftReg;
        reqTgl   <= ~reqTgl;
      end
    end
  end

endmodule

// File: rtl/segLoaderXfer.sv
`timescale 1ns/1ps
module segLoaderXfer #(
  parameter int GROUPS      = 4,
  parameter int GROUP_W     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = GROUPS * GROUP_W,
  parameter int SEL_W       = $clog2(GROUPS)
) (
  input  logic               dispClk,
  input  logic               rstN,
  input  logic               reqTgl,
  input  logic [WORD_W-1:0]  holdWord,
  input  logic [SEL_W-1:0]   bpPhase,
  output logic [WORD_W-1:0]  segWord,
  output logic [GROUP_W-1:0] grpData,
  output logic               frameUpd
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   seenQ;
  logic [GROUP_W-1:0]     grpArr [GROUPS];

  always_ff @(posedge dispClk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      seenQ    <= 1'b0;
      segWord  <= '0;
      frameUpd <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], reqTgl};
      seenQ <= syncQ[SYNC_STAGES-1];
      if (syncQ[SYNC_STAGES-1] != seenQ) begin
        segWord  <= holdWord;
        frameUpd <= 1'b1;
      end else begin
        frameUpd <= 1'b0;
      end
    end
  end

  // Group g is the g-th block of GROUP_W bits counted from the first bit received.
  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    assign grpArr[g] = segWord[WORD_W-1-g*GROUP_W -: GROUP_W];
  end

  assign grpData = grpArr[bpPhase];

endmodule

// File: rtl/segLoader.sv
`timescale 1ns/1ps
module segLoader
  import segLoaderPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int GROUPS      = 4,
  parameter int GROUP_W     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = GROUPS * GROUP_W,
  parameter int SEL_W       = $clog2(GROUPS),
  parameter int CNT_W       = $clog2(ADDR_W + WORD_W + 1)
) (
  input  logic               serClk,
  input  logic               dispClk,
  input  logic               rstN,
  input  logic               serData,
  input  logic               frameEn,
  input  logic               autoMode,
  input  logic [ADDR_W-1:0]  chipAddr,
  input  logic [SEL_W-1:0]   bpPhase,
  output logic [WORD_W-1:0]  segWord,
  output logic [GROUP_W-1:0] grpData,
  output logic               frameUpd
);

  loadStrobes_t      strb;
  logic [CNT_W-1:0]  cntQ;
  logic              matchQ;
  logic [ADDR_W-1:0] addrCand;
  logic [WORD_W-1:0] holdWord;
  logic              reqTgl;

  segLoaderCtrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) uCtrl (
    .serClk   (serClk),
    .rstN     (rstN),
    .autoMode (autoMode),
    .frameEn  (frameEn),
    .chipAddr (chipAddr),
    .addrCand (addrCand),
    .strb     (strb),
    .cntQ     (cntQ),
    .matchQ   (matchQ)
  );

  segLoaderData #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) uData (
    .serClk   (serClk),
    .rstN     (rstN),
    .serData  (serData),
    .strb     (strb),
    .addrCand (addrCand),
    .holdWord (holdWord),
    .reqTgl   (reqTgl)
  );

  segLoaderXfer #(
    .GROUPS(GROUPS), .GROUP_W(GROUP_W), .SYNC_STAGES(SYNC_STAGES),
    .WORD_W(WORD_W), .SEL_W(SEL_W)
  ) uXfer (
    .dispClk  (dispClk),
    .rstN     (rstN),
    .reqTgl   (reqTgl),
    .holdWord (holdWord),
    .bpPhase  (bpPhase),
    .segWord  (segWord),
    .grpData  (grpData),
    .frameUpd (frameUpd)
  );

endmodule

// File: rtl/segLoaderChk.sv
`timescale 1ns/1ps
module segLoaderChk
  import segLoaderPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 128,
  parameter int CNT_W  = $clog2(ADDR_W + WORD_W + 1)
) (
  input logic              serClk,
  input logic              dispClk,
  input logic              rstN,
  input logic              autoMode,
  input logic              frameEn,
  input loadStrobes_t      strb,
  input logic [CNT_W-1:0]  cntQ,
  input logic              matchQ,
  input logic [WORD_W-1:0] holdWord,
  input logic              reqTgl,
  input logic [WORD_W-1:0] segWord,
  input logic              frameUpd
);

  localparam logic [CNT_W-1:0] cLastBit = CNT_W'(ADDR_W + WORD_W - 1);
  localparam logic [CNT_W-1:0] cFull    = CNT_W'(ADDR_W + WORD_W);

  p_cnt_bound_r3: assert property (@(posedge serClk) disable iff (!rstN)
    cntQ <= cFull);

  p_auto_wrap_r3: assert property (@(posedge serClk) disable iff (!rstN)
    (autoMode && cntQ == cLastBit) |=> (cntQ == '0));

  p_latch_match_r2: assert property (@(posedge serClk) disable iff (!rstN)
    strb.latchNow |-> matchQ);

  p_clear_idle_r5: assert property (@(posedge serClk) disable iff (!rstN)
    (!autoMode && !frameEn) |=> (cntQ == '0 && !matchQ));

  p_toggle_r7: assert property (@(posedge serClk) disable iff (!rstN)
    strb.latchNow |=> (reqTgl != $past(reqTgl)));

  p_hold_stable_r7: assert property (@(posedge serClk) disable iff (!rstN)
    !strb.latchNow |=> $stable(holdWord));

  p_disp_upd_r7: assert property (@(posedge dispClk) disable iff (!rstN)
    !$stable(segWord) |-> frameUpd);

  p_upd_pulse_r7: assert property (@(posedge dispClk) disable iff (!rstN)
    frameUpd |=> !frameUpd);

endmodule

bind segLoader segLoaderChk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) uChk (
  .serClk   (serClk),
  .dispClk  (dispClk),
  .rstN     (rstN),
  .autoMode (autoMode),
  .frameEn  (frameEn),
  .strb     (strb),
  .cntQ     (cntQ),
  .matchQ   (matchQ),
  .holdWord (holdWord),
  .reqTgl   (reqTgl),
  .segWord  (segWord),
  .frameUpd (frameUpd)
);

// File: tb/sim_segLoader.sv
`timescale 1ns/1ps
module sim_segLoader;

  localparam int WORD_W  = 128;
  localparam int GROUP_W = 32;
  localparam int GROUPS  = 4;

  logic               serClk = 1'b0;
  logic               dispClk = 1'b0;
  logic               rstN = 1'b0;
  logic               serData = 1'b0;
  logic               frameEn = 1'b0;
  logic               autoMode = 1'b1;
  logic [2:0]         chipAddr = 3'd5;
  logic [1:0]         bpPhase = 2'd0;
  logic [WORD_W-1:0]  segWord;
  logic [GROUP_W-1:0] grpData;
  logic               frameUpd;

  int checks = 0;
  int errors = 0;
  int updCnt = 0;
  int expUpd = 0;
  logic [WORD_W-1:0] expWord = '0;

  segLoader u0 (
    .serClk(serClk), .dispClk(dispClk), .rstN(rstN), .serData(serData),
    .frameEn(frameEn), .autoMode(autoMode), .chipAddr(chipAddr),
    .bpPhase(bpPhase), .segWord(segWord), .grpData(grpData), .frameUpd(frameUpd)
  );

  always #5 dispClk = ~dispClk;

  always @(negedge dispClk) if (rstN && frameUpd) updCnt++;

  function automatic logic [WORD_W-1:0] pat(int k);
    logic [WORD_W-1:0] w;
    for (int g = 0; g < GROUPS; g++) begin
      w[g*GROUP_W +: GROUP_W] = (32'(k) * 32'h9E3779B9) ^ (32'(g) * 32'h7F4A7C15) ^ 32'hA5C3_0F1E;
    end
    return w;
  endfunction

  task automatic sendBit(input logic b);
    serData = b;
    #4 serClk = 1'b1;
    #9 serClk = 1'b0;
    #4;
  endtask

  task automatic sendAddr(input logic [2:0] a);
    for (int i = 2; i >= 0; i--) sendBit(a[i]);
  endtask

  task automatic sendBits(input logic [WORD_W-1:0] w, input int n);
    for (int i = WORD_W - 1; i >= WORD_W - n; i--) sendBit(w[i]);
  endtask

  task automatic settle();
    repeat (12) @(posedge dispClk);
    @(negedge dispClk);
  endtask

  task automatic chkWord(input string tag, input logic [WORD_W-1:0] exp);
    checks++;
    if (segWord !== exp) begin
      errors++;
      $display("FAIL %s segWord actual %h expected %h", tag, segWord, exp);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkGroups(input string tag, input logic [WORD_W-1:0] exp);
    for (int p = 0; p < GROUPS; p++) begin
      bpPhase = 2'(p);
      #1;
      checks++;
      if (grpData !== exp[WORD_W-1-p*GROUP_W -: GROUP_W]) begin
        errors++;
        $display("FAIL %s phase %0d grpData actual %h expected %h", tag, p, grpData,
                 exp[WORD_W-1-p*GROUP_W -: GROUP_W]);
      end
    end
    bpPhase = 2'd0;
  endtask

  // Enable-mode frame end: drop frameEn and give one serial clock edge.
  task automatic dropEnable();
    frameEn = 1'b0;
    sendBit(1'b0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired (R7 transfer never completed)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WORD_W-1:0] w;
    repeat (5) @(posedge dispClk);
    @(negedge dispClk);
    // R9: reset state
    chkWord("R9 reset word", '0);
    chkInt("R9 reset frameUpd", int'(frameUpd), 0);
    chkGroups("R9 reset groups", '0);
    rstN = 1'b1;
    repeat (2) @(negedge dispClk);

    // R1 / R3 / R8: matched frame in automatic mode
    w = pat(1);
    sendAddr(3'd5);
    sendBits(w, WORD_W);
    settle();
    expWord = w; expUpd++;
    chkWord("R1 first frame bit order", expWord);
    chkInt("R1 msb is first data bit", int'(segWord[127]), int'(w[127]));
    chkGroups("R8 group split", expWord);
    chkInt("R7 one update pulse", updCnt, expUpd);

    // R2: mismatched address ignored, then R3 resync on next frame
    sendAddr(3'd2);
    sendBits(pat(2), WORD_W);
    settle();
    chkWord("R2 mismatch ignored", expWord);
    chkInt("R2 no pulse on mismatch", updCnt, expUpd);
    w = pat(3);
    sendAddr(3'd5);
    sendBits(w, WORD_W);
    settle();
    expWord = w; expUpd++;
    chkWord("R3 next frame after ignored one", expWord);

    // R2 sweep: every chip address against every stream address
    for (int a = 0; a < 8; a++) begin
      chipAddr = 3'(a);
      for (int s = 0; s < 8; s++) begin
        w = pat(100 + a * 8 + s);
        sendAddr(3'(s));
        sendBits(w, WORD_W);
        settle();
        if (s == a) begin
          expWord = w; expUpd++;
        end
        chkWord($sformatf("R2 sweep chip %0d stream %0d", a, s), expWord);
      end
    end
    chkInt("R7 pulse count after sweep", updCnt, expUpd);

    // R3: frameEn toggling has no effect in automatic mode
    chipAddr = 3'd5;
    w = pat(150);
    frameEn = 1'b1;
    sendAddr(3'd5);
    sendBits(w, 64);
    frameEn = 1'b0;
    sendBits(w << 64, 64);
    settle();
    expWord = w; expUpd++;
    chkWord("R3 frameEn ignored in auto mode", expWord);

    // Switch to enable mode and clear state
    autoMode = 1'b0;
    frameEn  = 1'b0;
    sendBit(1'b0);

    // R4: no transfer while frameEn held, transfer on its fall
    w = pat(200);
    frameEn = 1'b1;
    sendAddr(3'd5);
    sendBits(w, WORD_W);
    settle();
    chkWord("R4 no transfer while enable held", expWord);
    dropEnable();
    settle();
    expWord = w; expUpd++;
    chkWord("R4 transfer on enable fall", expWord);
    chkGroups("R8 groups enable mode", expWord);

    // R5: short frame discarded, next full frame accepted
    frameEn = 1'b1;
    sendAddr(3'd5);
    sendBits(pat(201), 100);
    dropEnable();
    settle();
    chkWord("R5 short frame discarded", expWord);
    chkInt("R5 no pulse for short frame", updCnt, expUpd);
    w = pat(202);
    frameEn = 1'b1;
    sendAddr(3'd5);
    sendBits(w, WORD_W);
    dropEnable();
    settle();
    expWord = w; expUpd++;
    chkWord("R5 count restarted after short frame", expWord);

    // R6: extra bits keep shifting; last 128 kept
    w = pat(203);
    frameEn = 1'b1;
    sendAddr(3'd5);
    sendBits(w, WORD_W);
    sendBits({8'hC3, 120'd0}, 8);
    dropEnable();
    settle();
    expWord = {w[119:0], 8'hC3}; expUpd++;
    chkWord("R6 last 128 bits kept", expWord);

    // R2 in enable mode: mismatched frame ignored
    frameEn = 1'b1;
    sendAddr(3'd6);
    sendBits(pat(204), WORD_W);
    dropEnable();
    settle();
    chkWord("R2 mismatch in enable mode", expWord);

    // R5: partial address cleared by enable low
    frameEn = 1'b1;
    sendBit(1'b0);
    sendBit(1'b1);
    dropEnable();
    w = pat(205);
    frameEn = 1'b1;
    sendAddr(3'd5);
    sendBits(w, WORD_W);
    dropEnable();
    settle();
    expWord = w; expUpd++;
    chkWord("R5 partial address cleared", expWord);
    chkInt("R7 total update pulses", updCnt, expUpd);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule